// File: doc/BRIEF.md
# Wait-State Memory Bus Controller

This block is the processor-side master of a simple parallel memory bus. It runs one single-word read or write at a time. A one-cycle start request carries the address, the direction and the write data. The controller then steps through a fixed order of phases: address first, then the active-low read or write strobe, then the data. For a write, the data is put on the bus one cycle after the strobe falls. A memory-ready input lets slow memory stretch the strobe by any number of wait cycles.

When ready is seen high, the controller captures read data and releases the strobe. It then gives a one-cycle done pulse. The shared data bus is modelled as a separate output bus with an enable and a separate input bus. A busy output covers the whole transfer, and start requests that arrive while busy is high are dropped. Burst transfers, byte enables and arbitration between masters are not part of this block.

Top module: `wsbus_master`

## Requirements
- R1: While reset is held and after it is released, with no request given, `bus_rd_n` and `bus_wr_n` are 1, `bus_dout_en`, `busy` and `rsp_done` are 0.
- R2: A start accepted while idle puts `req_addr` on `bus_addr` in the next cycle. Both strobes stay high for `ADDR_SETUP` cycles (default 1) before either strobe falls. `bus_addr` then holds that value until `busy` falls.
- R3: In a read (`req_write` = 0), `bus_rd_n` is 0 from the end of the address phase until ready is accepted, while `bus_wr_n` stays 1. `bus_dout_en` stays 0 for the whole read.
- R4: In a write (`req_write` = 1), `bus_wr_n` falls first while `bus_dout_en` is still 0. From the next cycle until ready is accepted, `bus_dout_en` is 1 and `bus_dout` equals the latched write data. `bus_rd_n` stays 1.
- R5: `bus_ready` is sampled only in the wait phase, which starts one cycle after the strobe falls. A high ready during the first strobe cycle has no effect, so a strobe lasts at least two cycles. While ready stays low the strobe stays low. With W wait-phase edges at which ready is low, `rsp_done` is high in the cycle after the (`ADDR_SETUP` + 2 + W)-th rising edge that follows the edge accepting the start.
- R6: Read data on `bus_din` is captured into `rsp_rdata` at the edge where ready is seen high. The captured value is shown while `rsp_done` is high and is held unchanged until the next read completes. Writes never change it.
- R7: `rsp_done` is a one-cycle pulse, and both strobes are high and `bus_dout_en` is 0 in that cycle. `busy` is 1 from the cycle after the accepting edge through the done cycle, and 0 in the cycle after it.
- R8: A start request while `busy` is 1 is ignored. The address, direction, strobe pattern and write data of the transfer in flight do not change.
- R9: `bus_rd_n` and `bus_wr_n` are never both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_start | input | 1 | One-cycle transfer request, taken only while idle |
| req_write | input | 1 | Direction of the request: 1 write, 0 read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Data for a write |
| rsp_rdata | output | DW | Last captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| bus_addr | output | AW | Memory address bus |
| bus_dout | output | DW | Outgoing half of the data bus |
| bus_dout_en | output | 1 | Drive enable for the outgoing data |
| bus_din | input | DW | Incoming half of the data bus |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ready | input | 1 | Memory ready, ends the wait phase |

## Verification
Some rules are checked by the bound checker on every cycle:
- the two strobes are never low together;
- the address is stable while busy;
- a strobe never falls without a preceding address cycle;
- the data drive never overlaps a read strobe or the first write-strobe cycle;
- done follows an accepted ready and always coincides with a strobe release;
- captured read data changes only at completion.

Other behaviour can only be shown by the bench's directed scenarios:
- the exact latency for zero, short and long wait counts;
- the read value itself, including data that changes on the bus after capture;
- a read value held across a later write;
- a start request dropped in the middle of a transfer.

// File: rtl/wsbus_pkg.sv
// Package: shared phase encoding for the wait-state bus master.
// Assumes: one transfer at a time; phases are visited strictly in order.
package wsbus_pkg;

    // Transfer phases, visited in this order for every transfer.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,  // no transfer, strobes high
        PH_ADDR   = 3'd1,  // address driven, strobes still high
        PH_STROBE = 3'd2,  // strobe low, ready not yet sampled
        PH_WAIT   = 3'd3,  // strobe low, write data driven, ready sampled
        PH_DONE   = 3'd4   // strobe released, completion pulse
    } wsbus_phase_e;

endpackage

// File: rtl/wsbus_sequencer.sv
// Module: phase sequencer of the bus master.
// Walks idle -> address -> strobe -> wait -> done -> idle.
// Holds the address phase for ADDR_SETUP cycles.
// Assumes: ADDR_SETUP >= 1; ready is synchronous to clk.
module wsbus_sequencer
    import wsbus_pkg::*;
#(
    parameter int ADDR_SETUP = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         ready,
    output wsbus_phase_e phase,
    output logic         accept
);

    localparam int CW = (ADDR_SETUP > 1) ? $clog2(ADDR_SETUP) : 1;
    localparam logic [CW-1:0] SETUP_LAST = CW'(ADDR_SETUP - 1);

    wsbus_phase_e  phase_q, phase_d;
    logic [CW-1:0] setup_cnt_q;

    // A start is taken only while no transfer is running.
    assign accept = start && (phase_q == PH_IDLE);
    assign phase  = phase_q;

    // Next-phase decision.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (accept) phase_d = PH_ADDR;
            PH_ADDR:   if (setup_cnt_q == SETUP_LAST) phase_d = PH_STROBE;
            PH_STROBE: phase_d = PH_WAIT;
            PH_WAIT:   if (ready) phase_d = PH_DONE;
            PH_DONE:   phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Address setup counter, cleared outside the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                 setup_cnt_q <= '0;
        else if (phase_q == PH_ADDR) setup_cnt_q <= setup_cnt_q + 1'b1;
        else                        setup_cnt_q <= '0;
    end

endmodule

// File: rtl/wsbus_xfer_latch.sv
// Module: request latch.
// Holds address, direction and write data from the accepted start until
// the next accepted start.
// Assumes: accept is high for exactly one cycle per transfer.
module wsbus_xfer_latch #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          in_write,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    output logic          is_write,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);

    // Capture the request fields when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_write <= 1'b0;
            addr     <= '0;
            wdata    <= '0;
        end else if (accept) begin
            is_write <= in_write;
            addr     <= in_addr;
            wdata    <= in_wdata;
        end
    end

endmodule

// File: rtl/wsbus_read_capture.sv
// Module: read data register.
// Loads the incoming bus data on the edge where ready ends the wait phase
// of a read, then holds it.
// Assumes: bus_din is valid whenever ready is high in the wait phase.
module wsbus_read_capture
    import wsbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wsbus_phase_e  phase,
    input  logic          is_write,
    input  logic          ready,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rdata
);

    logic load;
    assign load = (phase == PH_WAIT) && ready && !is_write;

    // Hold register for the last completed read.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata <= '0;
        else if (load) rdata <= din;
    end

endmodule

// File: rtl/wsbus_pin_drive.sv
// Module: bus pin decode.
// Turns the registered phase and direction into strobes, data enable,
// busy and done.
// Assumes: phase and is_write come straight from flops, so the decoded
// pins change only after clock edges.
module wsbus_pin_drive
    import wsbus_pkg::*;
(
    input  wsbus_phase_e phase,
    input  logic         is_write,
    output logic         rd_n,
    output logic         wr_n,
    output logic         dout_en,
    output logic         busy,
    output logic         done
);

    logic strobe_on;

    // Strobe and data-enable decode.
    always_comb begin
        strobe_on = (phase == PH_STROBE) || (phase == PH_WAIT);
        rd_n      = !(strobe_on && !is_write);
        wr_n      = !(strobe_on && is_write);
        dout_en   = (phase == PH_WAIT) && is_write;
    end

    // Handshake decode toward the requester.
    always_comb begin
        busy = (phase != PH_IDLE);
        done = (phase == PH_DONE);
    end

endmodule

// File: rtl/wsbus_master.sv
// Module: wait-state memory bus master (top).
// Runs single reads and writes with an ordered address / strobe / data
// sequence and ready-controlled wait states.
// Assumes: synchronous memory ready; the shared data bus is built outside
// from bus_dout, bus_dout_en and bus_din.
module wsbus_master
    import wsbus_pkg::*;
#(
    parameter int AW         = 20,
    parameter int DW         = 16,
    parameter int ADDR_SETUP = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_start,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic          busy,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    input  logic [DW-1:0] bus_din,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    input  logic          bus_ready
);

    wsbus_phase_e phase;
    logic         accept;
    logic         is_write;

    wsbus_sequencer #(.ADDR_SETUP(ADDR_SETUP)) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (req_start),
        .ready  (bus_ready),
        .phase  (phase),
        .accept (accept)
    );

    wsbus_xfer_latch #(.AW(AW), .DW(DW)) latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .in_write (req_write),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .is_write (is_write),
        .addr     (bus_addr),
        .wdata    (bus_dout)
    );

    wsbus_read_capture #(.DW(DW)) rcap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .is_write (is_write),
        .ready    (bus_ready),
        .din      (bus_din),
        .rdata    (rsp_rdata)
    );

    wsbus_pin_drive pins_i (
        .phase    (phase),
        .is_write (is_write),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .dout_en  (bus_dout_en),
        .busy     (busy),
        .done     (rsp_done)
    );

endmodule

// File: rtl/wsbus_master_checker.sv
// Module: protocol checker for wsbus_master, attached through bind.
// Assumes: observes top-level ports only.
module wsbus_master_checker #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] rsp_rdata,
    input logic          rsp_done,
    input logic          busy,
    input logic [AW-1:0] bus_addr,
    input logic          bus_dout_en,
    input logic          bus_rd_n,
    input logic          bus_wr_n,
    input logic          bus_ready
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_rd_n && bus_wr_n && !bus_dout_en && !rsp_done));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_addr));

    p_addr_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(busy));

    p_read_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_dout_en);

    p_write_data_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wr_n) |-> !bus_dout_en);

    p_drive_in_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> !bus_wr_n);

    p_done_after_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(bus_ready));

    p_rdata_only_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_rdata) |-> rsp_done);

    p_release_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> rsp_done);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && !busy));

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_n || bus_wr_n);

endmodule

bind wsbus_master wsbus_master_checker #(.AW(AW), .DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_rdata   (rsp_rdata),
    .rsp_done    (rsp_done),
    .busy        (busy),
    .bus_addr    (bus_addr),
    .bus_dout_en (bus_dout_en),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_ready   (bus_ready)
);

// File: tb/wsbus_master_tb_top.sv
// Directed bench for wsbus_master: one task per scenario.
module wsbus_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int SETUP = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;
    logic          busy;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout;
    logic          bus_dout_en;
    logic [DW-1:0] bus_din = '0;
    logic          bus_rd_n;
    logic          bus_wr_n;
    logic          bus_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] last_rd = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wsbus_master #(.AW(AW), .DW(DW), .ADDR_SETUP(SETUP)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance one clock and settle just after the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // One full transfer, checked cycle by cycle.
    task automatic do_xfer(input bit wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input int waits,
                           input logic [DW-1:0] rmem, input bit poke);
        int lat;
        req_write = wr; req_addr = a; req_wdata = wd; req_start = 1'b1;
        bus_ready = 1'b0;
        step(); lat = 1;
        req_start = 1'b0; req_addr = ~a; req_wdata = ~wd;
        // Address phase.
        for (int s = 0; s < SETUP; s++) begin
            chk(busy == 1'b1, "R7", "busy in address phase", busy, 1);
            chk(bus_addr == a, "R2", "address in address phase", bus_addr, a);
            chk(bus_rd_n && bus_wr_n, "R2", "strobes high in address phase",
                {bus_rd_n, bus_wr_n}, 2'b11);
            if (s < SETUP - 1) begin step(); lat++; end
        end
        step(); lat++;
        // First strobe cycle.
        chk(bus_rd_n == wr && bus_wr_n == !wr, wr ? "R4" : "R3",
            "strobe pattern in first strobe cycle", {bus_rd_n, bus_wr_n}, {wr, !wr});
        chk(bus_dout_en == 1'b0, wr ? "R4" : "R3", "no drive in first strobe cycle",
            bus_dout_en, 0);
        bus_ready = (waits == 0);
        bus_din = rmem;
        step(); lat++;
        // Wait phase.
        for (int i = 0; i <= waits; i++) begin
            chk(bus_rd_n == wr && bus_wr_n == !wr, "R5", "strobe held in wait",
                {bus_rd_n, bus_wr_n}, {wr, !wr});
            chk(rsp_done == 1'b0, "R5", "no done while waiting", rsp_done, 0);
            chk(bus_addr == a, poke ? "R8" : "R2", "address held in wait", bus_addr, a);
            chk(bus_dout_en == wr, wr ? "R4" : "R3", "data enable in wait", bus_dout_en, wr);
            if (wr)
                chk(bus_dout == wd, "R4", "write data on bus", bus_dout, wd);
            if (poke && i == 0) begin
                req_start = 1'b1; req_write = !wr; req_addr = ~a;
            end
            if (i == waits) bus_ready = 1'b1;
            step(); lat++;
            req_start = 1'b0;
        end
        // Done cycle.
        bus_ready = 1'b0;
        bus_din = ~rmem;
        chk(rsp_done == 1'b1, "R5", "done after ready", rsp_done, 1);
        chk(lat == SETUP + 3 + waits, "R5", "latency in edges", lat, SETUP + 3 + waits);
        chk(bus_rd_n && bus_wr_n && !bus_dout_en, "R7", "released in done cycle",
            {bus_rd_n, bus_wr_n, bus_dout_en}, 3'b110);
        chk(busy == 1'b1, "R7", "busy in done cycle", busy, 1);
        if (!wr) last_rd = rmem;
        chk(rsp_rdata == last_rd, wr ? "R6" : "R6", "read data at done", rsp_rdata, last_rd);
        step();
        chk(rsp_done == 1'b0 && busy == 1'b0, "R7", "done is one pulse, busy drops",
            {rsp_done, busy}, 2'b00);
        chk(rsp_rdata == last_rd, "R6", "read data held after done", rsp_rdata, last_rd);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk(bus_rd_n && bus_wr_n, "R1", "strobes high in reset", {bus_rd_n, bus_wr_n}, 2'b11);
        chk(!bus_dout_en && !busy && !rsp_done, "R1", "quiet in reset",
            {bus_dout_en, busy, rsp_done}, 3'b000);
        rst_n = 1'b1;
        repeat (3) step();
        chk(bus_rd_n && bus_wr_n && !bus_dout_en && !busy, "R1", "idle after reset",
            {bus_rd_n, bus_wr_n, bus_dout_en, busy}, 4'b1100);
    endtask

    task automatic t_read_fast();  do_xfer(1'b0, 20'hA23C0, 16'h0000, 0, 16'h5A3C, 1'b0); endtask
    task automatic t_read_slow();  do_xfer(1'b0, 20'h02920, 16'h0000, 3, 16'hC0DE, 1'b0); endtask
    task automatic t_write_fast(); do_xfer(1'b1, 20'h28F30, 16'hBEEF, 0, 16'h1111, 1'b0); endtask
    task automatic t_write_slow(); do_xfer(1'b1, 20'hFFFFF, 16'h8001, 5, 16'h2222, 1'b0); endtask
    task automatic t_long_wait();  do_xfer(1'b0, 20'h00001, 16'h0000, 40, 16'h7E57, 1'b0); endtask

    // R8: a start during a read and during a write must be dropped.
    task automatic t_busy_start();
        do_xfer(1'b0, 20'h12345, 16'h0000, 2, 16'h4321, 1'b1);
        do_xfer(1'b1, 20'h54321, 16'hA5A5, 2, 16'h3333, 1'b1);
        repeat (2) step();
        chk(busy == 1'b0, "R8", "dropped start leaves block idle", busy, 0);
    endtask

    // R6: writes between reads leave the captured read data alone.
    task automatic t_rdata_kept();
        do_xfer(1'b0, 20'h00400, 16'h0000, 1, 16'h9876, 1'b0);
        do_xfer(1'b1, 20'h00404, 16'h0F0F, 1, 16'hFFFF, 1'b0);
        chk(rsp_rdata == 16'h9876, "R6", "read data after write", rsp_rdata, 16'h9876);
    endtask

    // Back-to-back starts on the idle cycle right after done.
    task automatic t_back_to_back();
        for (int k = 0; k < 4; k++)
            do_xfer(k[0], AW'(20'h10000 + k), DW'(16'h1000 + k), k, DW'(16'h2000 + k), 1'b0);
    endtask

    initial begin
        t_reset();
        t_read_fast();
        t_read_slow();
        t_write_fast();
        t_write_slow();
        t_long_wait();
        t_busy_start();
        t_rdata_kept();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule